// File: doc/BRIEF.md
# Eight-Channel DAC State and Power Controller

This block holds the whole digital state of an eight-channel voltage DAC behind an already decoded command interface. Every channel has an input (staging) register, a DAC register that drives the converter, and a power-down flag. The block also has two reference flags: one selects internal or external reference, and one shows that the internal reference is powered down. A serial front end delivers one command per `cmd_valid` pulse as a 4-bit code, a 4-bit channel address and a data word. The block applies the command on that clock edge. All state is visible on registered outputs that set the analog circuitry.

Power management follows two rules. First, how the internal reference comes back depends on the command that turned it off. Second, when a powered-down channel is woken by a DAC update, `busy` is raised for a settling time that is counted in system clocks. That time is longer when the whole device was asleep before the update. The input and DAC registers keep their contents across power-down.

Top module: `dac_state_ctrl`

## Requirements
- R1: After reset all input and DAC registers are zero, every channel is powered up, `busy` is low, and `ref_ext` and `ref_off` both equal the `EXT_REF_DEFAULT` parameter.
- R2: Code 0000b loads `cmd_data` into the input register of channel `cmd_addr` and leaves DAC registers unchanged. Address 1111b selects every channel. Addresses 8 to 14 change no register.
- R3: Code 0001b copies the input register of the addressed channel (or of all channels for address 1111b) into its DAC register.
- R4: Code 0010b loads `cmd_data` into input register n. It then loads every DAC register from its input register, and channel n takes the new data.
- R5: Code 0011b loads `cmd_data` into both the input register and the DAC register of channel n.
- R6: Code 0100b sets the power-down flag of the addressed channel(s). The data field is ignored, and no register contents change.
- R7: Code 0101b powers down all channels and the internal reference in one step. The data field is ignored, and register contents are kept.
- R8: Every channel whose DAC register is loaded (codes 0001b, 0010b, 0011b) has its power-down flag cleared. Code 0000b never clears a power-down flag.
- R9: Code 0110b sets `ref_ext`=0 and `ref_off`=0. Code 0111b sets `ref_ext`=1 and `ref_off`=1.
- R10: A reference turned off by 0111b stays off through any other command until 0110b arrives. A reference turned off only by 0101b is turned back on by any DAC-updating command.
- R11: A DAC update that wakes at least one powered-down channel raises `busy` for exactly CLK_HZ/1e6 × SHORT_US cycles. `busy` first reads high after the command edge. An update of channels that are all powered up leaves `busy` low.
- R12: When all channels and the reference were off before the waking update, `busy` lasts CLK_HZ/1e6 × LONG_US cycles instead.
- R13: Codes 1000b to 1111b change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 4 | Command code |
| cmd_addr | input | 4 | Channel address, 1111b = all |
| cmd_data | input | DATA_W | Data word |
| in_regs | output | NCH*DATA_W | Input registers, channel i at bits [i*DATA_W +: DATA_W] |
| dac_regs | output | NCH*DATA_W | DAC registers, same packing |
| ch_off | output | NCH | Per-channel power-down flags |
| ref_off | output | 1 | Internal reference powered down |
| ref_ext | output | 1 | External reference selected |
| busy | output | 1 | Power-up settling in progress |

## Verification
On every cycle the assertions check these command-to-state effects: a channel power-down leaves both register banks unchanged; a chip power-down turns off every channel and the reference; the reference-select commands set both reference flags; a reference locked by external selection stays off; and a waking update raises `busy`. The exact `busy` length, and the choice between the short and long delay, can only be shown by the bench's scenarios. The same holds for the two reference restore paths and for the writes to unused addresses or codes that must change nothing. The bench counts the delay cycles itself and compares each register against values that follow from the command sequence.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  typedef enum logic [3:0] {
    OP_LOAD_IN     = 4'h0,
    OP_PUSH        = 4'h1,
    OP_LOAD_PUSHALL = 4'h2,
    OP_LOAD_PUSH   = 4'h3,
    OP_SLEEP_CH    = 4'h4,
    OP_SLEEP_CHIP  = 4'h5,
    OP_REF_INT     = 4'h6,
    OP_REF_EXT     = 4'h7
  } dac_op_e;

  localparam logic [3:0] ADDR_BROADCAST = 4'hF;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           valid,
  input  logic [3:0]     code,
  input  logic [3:0]     addr,
  output logic [NCH-1:0] load_mask,
  output logic [NCH-1:0] push_mask,
  output logic [NCH-1:0] sleep_mask,
  output logic           sleep_chip,
  output logic           ref_int,
  output logic           ref_ext
);
  logic [NCH-1:0] sel;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_BROADCAST) || (addr == 4'(i));
  end

  always_comb begin
    load_mask  = '0;
    push_mask  = '0;
    sleep_mask = '0;
    sleep_chip = 1'b0;
    ref_int    = 1'b0;
    ref_ext    = 1'b0;
    if (valid) begin
      case (code)
        OP_LOAD_IN:      load_mask = sel;
        OP_PUSH:         push_mask = sel;
        OP_LOAD_PUSHALL: begin
          load_mask = sel;
          push_mask = '1;
        end
        OP_LOAD_PUSH: begin
          load_mask = sel;
          push_mask = sel;
        end
        OP_SLEEP_CH:     sleep_mask = sel;
        OP_SLEEP_CHIP:   sleep_chip = 1'b1;
        OP_REF_INT:      ref_int    = 1'b1;
        OP_REF_EXT:      ref_ext    = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              push,
  input  logic              sleep,
  input  logic              sleep_chip,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] dac_q,
  output logic              off_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      dac_q <= '0;
      off_q <= 1'b0;
    end else begin
      if (load) in_q <= data;
      if (push) dac_q <= load ? data : in_q;
      if (push) off_q <= 1'b0;
      else if (sleep || sleep_chip) off_q <= 1'b1;
    end
  end

  // R8: a loaded DAC register always leaves the channel awake
  a_r8_push_wakes: assert property (@(posedge clk) disable iff (rst)
    push |=> !off_q);
endmodule

// File: rtl/dac_ref_ctrl.sv
module dac_ref_ctrl #(
  parameter bit EXT_REF_DEFAULT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_int,
  input  logic sel_ext,
  input  logic sleep_chip,
  input  logic any_push,
  output logic ext_q,
  output logic off_q
);
  logic locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q    <= EXT_REF_DEFAULT;
      off_q    <= EXT_REF_DEFAULT;
      locked_q <= EXT_REF_DEFAULT;
    end else if (sel_int) begin
      ext_q    <= 1'b0;
      off_q    <= 1'b0;
      locked_q <= 1'b0;
    end else if (sel_ext) begin
      ext_q    <= 1'b1;
      off_q    <= 1'b1;
      locked_q <= 1'b1;
    end else if (sleep_chip) begin
      off_q <= 1'b1;
    end else if (any_push && !locked_q) begin
      off_q <= 1'b0;
    end
  end

  // R10: external selection keeps the reference off until internal select
  a_r10_lock_holds: assert property (@(posedge clk) disable iff (rst)
    locked_q && !sel_int |=> off_q);
  a_r9_int_restores: assert property (@(posedge clk) disable iff (rst)
    sel_int |=> !off_q && !ext_q);
endmodule

// File: rtl/dac_settle_timer.sv
module dac_settle_timer #(
  parameter int SHORT_CYC = 500,
  parameter int LONG_CYC  = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_sel,
  output logic busy
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= long_sel ? LONG_LD : SHORT_LD;
      busy  <= 1'b1;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  // R11: a wake request always produces a settling window
  a_r11_start_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  a_r12_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt_q < CW'(MAXC));
endmodule

// File: rtl/dac_state_ctrl.sv
module dac_state_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int NCH             = 8,
  parameter int DATA_W          = 12,
  parameter int CLK_HZ          = 50_000_000,
  parameter int SHORT_US        = 10,
  parameter int LONG_US         = 12,
  parameter bit EXT_REF_DEFAULT = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [3:0]            cmd_code,
  input  logic [3:0]            cmd_addr,
  input  logic [DATA_W-1:0]     cmd_data,
  output logic [NCH*DATA_W-1:0] in_regs,
  output logic [NCH*DATA_W-1:0] dac_regs,
  output logic [NCH-1:0]        ch_off,
  output logic                  ref_off,
  output logic                  ref_ext,
  output logic                  busy
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int SHORT_CYC  = CYC_PER_US * SHORT_US;
  localparam int LONG_CYC   = CYC_PER_US * LONG_US;

  logic [NCH-1:0] load_mask, push_mask, sleep_mask;
  logic           sleep_chip, sel_int, sel_ext;
  logic           wake, all_asleep;

  dac_cmd_decode #(.NCH(NCH)) u_dec (
    .valid      (cmd_valid),
    .code       (cmd_code),
    .addr       (cmd_addr),
    .load_mask  (load_mask),
    .push_mask  (push_mask),
    .sleep_mask (sleep_mask),
    .sleep_chip (sleep_chip),
    .ref_int    (sel_int),
    .ref_ext    (sel_ext)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dac_channel #(.DATA_W(DATA_W)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .load       (load_mask[i]),
      .push       (push_mask[i]),
      .sleep      (sleep_mask[i]),
      .sleep_chip (sleep_chip),
      .data       (cmd_data),
      .in_q       (in_regs[i*DATA_W +: DATA_W]),
      .dac_q      (dac_regs[i*DATA_W +: DATA_W]),
      .off_q      (ch_off[i])
    );
  end

  dac_ref_ctrl #(.EXT_REF_DEFAULT(EXT_REF_DEFAULT)) u_ref (
    .clk        (clk),
    .rst        (rst),
    .sel_int    (sel_int),
    .sel_ext    (sel_ext),
    .sleep_chip (sleep_chip),
    .any_push   (|push_mask),
    .ext_q      (ref_ext),
    .off_q      (ref_off)
  );

  assign wake       = |(push_mask & ch_off);
  assign all_asleep = (&ch_off) && ref_off;

  dac_settle_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start    (wake),
    .long_sel (all_asleep),
    .busy     (busy)
  );

  // R6: channel power-down leaves both register banks untouched
  a_r6_sleep_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_code == OP_SLEEP_CH |=> $stable(in_regs) && $stable(dac_regs));
  // R7: chip power-down turns everything off
  a_r7_chip_off: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_code == OP_SLEEP_CHIP |=> (&ch_off) && ref_off);
  // R9: external select turns internal reference off
  a_r9_ext_sel: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_code == OP_REF_EXT |=> ref_ext && ref_off);
  // R4: update-all leaves no channel asleep
  a_r4_all_awake: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_code == OP_LOAD_PUSHALL |=> ch_off == '0);
endmodule

// File: tb/sim_dac_state_ctrl.sv
module sim_dac_state_ctrl;
  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int SHORT_CYC = 500;
  localparam int LONG_CYC  = 600;

  logic clk = 1'b0;
  logic rst;
  logic cmd_valid;
  logic [3:0] cmd_code, cmd_addr;
  logic [DW-1:0] cmd_data;
  logic [NCH*DW-1:0] in_regs, dac_regs;
  logic [NCH-1:0] ch_off;
  logic ref_off, ref_ext, busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  dac_state_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .in_regs(in_regs),
    .dac_regs(dac_regs), .ch_off(ch_off), .ref_off(ref_off),
    .ref_ext(ref_ext), .busy(busy)
  );

  function automatic logic [DW-1:0] in_of(int ch);
    return in_regs[ch*DW +: DW];
  endfunction
  function automatic logic [DW-1:0] dac_of(int ch);
    return dac_regs[ch*DW +: DW];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_data = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_busy_len(input int len, input string req);
    chk(busy == 1'b1, req, busy, 1);
    repeat (len - 1) @(negedge clk);
    chk(busy == 1'b1, req, busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, req, busy, 0);
  endtask

  task automatic t_reset();
    chk(in_regs == '0 && dac_regs == '0, "R1", dac_regs, 0);
    chk(ch_off == '0, "R1", ch_off, 0);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(ref_off == 1'b0 && ref_ext == 1'b0, "R1", {ref_off, ref_ext}, 0);
  endtask

  task automatic t_load_input();
    send(4'h0, 4'd2, 12'h5A5);
    chk(in_of(2) == 12'h5A5, "R2", in_of(2), 12'h5A5);
    chk(dac_of(2) == 12'h000, "R2", dac_of(2), 0);
    chk(in_of(1) == 12'h000, "R2", in_of(1), 0);
  endtask

  task automatic t_push();
    send(4'h1, 4'd2, 12'h0FF);
    chk(dac_of(2) == 12'h5A5, "R3", dac_of(2), 12'h5A5);
    chk(dac_of(3) == 12'h000, "R3", dac_of(3), 0);
  endtask

  task automatic t_load_push();
    send(4'h3, 4'd5, 12'h123);
    chk(in_of(5) == 12'h123 && dac_of(5) == 12'h123, "R5", dac_of(5), 12'h123);
    chk(busy == 1'b0, "R11", busy, 0);
  endtask

  task automatic t_push_all();
    send(4'h0, 4'd0, 12'h111);
    send(4'h2, 4'd7, 12'h777);
    chk(dac_of(7) == 12'h777, "R4", dac_of(7), 12'h777);
    chk(dac_of(0) == 12'h111, "R4", dac_of(0), 12'h111);
    chk(dac_of(2) == 12'h5A5 && dac_of(5) == 12'h123, "R4", dac_of(2), 12'h5A5);
    chk(dac_of(1) == 12'h000, "R4", dac_of(1), 0);
  endtask

  task automatic t_broadcast();
    logic [NCH*DW-1:0] sv_in, sv_dac;
    send(4'h0, 4'hF, 12'hABC);
    chk(in_of(3) == 12'hABC && in_of(6) == 12'hABC, "R2", in_of(3), 12'hABC);
    chk(dac_of(0) == 12'h111, "R2", dac_of(0), 12'h111);
    sv_in = in_regs; sv_dac = dac_regs;
    send(4'h0, 4'd9, 12'h999);
    send(4'h3, 4'd12, 12'h999);
    chk(in_regs == sv_in && dac_regs == sv_dac, "R2", in_regs, sv_in);
  endtask

  task automatic t_sleep_channel();
    logic [DW-1:0] d3;
    d3 = dac_of(3);
    send(4'h4, 4'd3, 12'hFFF);
    chk(ch_off == 8'h08, "R6", ch_off, 8'h08);
    chk(in_of(3) == 12'hABC && dac_of(3) == d3, "R6", dac_of(3), d3);
    chk(busy == 1'b0, "R6", busy, 0);
    send(4'h0, 4'd3, 12'h222);
    chk(ch_off == 8'h08, "R8", ch_off, 8'h08);
    send(4'h1, 4'd3, 12'h000);
    chk(ch_off == 8'h00, "R8", ch_off, 0);
    chk(dac_of(3) == 12'h222, "R8", dac_of(3), 12'h222);
    check_busy_len(SHORT_CYC, "R11");
  endtask

  task automatic t_chip_sleep();
    logic [NCH*DW-1:0] sv_dac;
    sv_dac = dac_regs;
    send(4'h5, 4'd0, 12'hFFF);
    chk(ch_off == 8'hFF && ref_off == 1'b1, "R7", {ref_off, ch_off}, 9'h1FF);
    chk(dac_regs == sv_dac, "R7", dac_regs, sv_dac);
    send(4'h3, 4'd1, 12'h321);
    chk(ch_off == 8'hFD, "R8", ch_off, 8'hFD);
    chk(ref_off == 1'b0, "R10", ref_off, 0);
    check_busy_len(LONG_CYC, "R12");
    send(4'h1, 4'hF, 12'h000);
    chk(ch_off == 8'h00, "R8", ch_off, 0);
    check_busy_len(SHORT_CYC, "R11");
  endtask

  task automatic t_ext_ref();
    send(4'h7, 4'd0, 12'h000);
    chk(ref_ext == 1'b1 && ref_off == 1'b1, "R9", {ref_ext, ref_off}, 2'b11);
    send(4'h3, 4'd0, 12'h010);
    chk(ref_off == 1'b1, "R10", ref_off, 1);
    send(4'h5, 4'd0, 12'h000);
    send(4'h1, 4'hF, 12'h000);
    chk(ref_off == 1'b1, "R10", ref_off, 1);
    chk(ch_off == 8'h00, "R8", ch_off, 0);
    check_busy_len(LONG_CYC, "R12");
    send(4'h6, 4'd0, 12'h000);
    chk(ref_ext == 1'b0 && ref_off == 1'b0, "R9", {ref_ext, ref_off}, 0);
  endtask

  task automatic t_unused_codes();
    logic [NCH*DW-1:0] sv_in, sv_dac;
    sv_in = in_regs; sv_dac = dac_regs;
    send(4'hA, 4'd2, 12'h0F0);
    send(4'hF, 4'hF, 12'hFFF);
    chk(in_regs == sv_in && dac_regs == sv_dac, "R13", dac_regs, sv_dac);
    chk(ch_off == 8'h00 && !ref_off && !ref_ext && !busy, "R13",
        {busy, ref_ext, ref_off, ch_off}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_code = '0; cmd_addr = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_input();
    t_push();
    t_load_push();
    t_push_all();
    t_broadcast();
    t_sleep_channel();
    wait_idle();
    t_chip_sleep();
    wait_idle();
    t_ext_ref();
    wait_idle();
    t_unused_codes();
    finish_run();
  end
endmodule